// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a synchronous, cycle-level model of the command front end of a parallel 16-bit NOR flash. It watches two active-low write strobes: a chip select `ce_n` and a write strobe `we_n`. From each write pulse it takes one address word and one data word. It decodes the unlock-guarded command streams from those writes. Recognised commands start a timed internal operation on a small register array: a word program, a sector erase or a block erase. New commands are ignored while that operation runs.

A running erase can be put on hold with a one-write suspend command and continued later with a one-write resume command. While the erase is on hold, words outside the held region may still be programmed. A write-protect input makes the block refuse any erase that targets the protected block.

The array is read through a separate combinational read port. Operation lengths, array geometry and the position of the protected block are parameters.

Top module: `flash_cmd_core`

## Requirements
- R1: After reset `busy` and `erase_held` are 0 and every array word reads FFFFh.
- R2: A write's address is taken at the clock where the second of `ce_n`/`we_n` is first seen low. Its data is taken at the clock where the first of them is first seen high. This holds whichever strobe leads.
- R3: Word program is 5555h/AAh, 2AAAh/55h and 5555h/A0h, then a fourth write carrying the target address and data. Opcodes are compared on data bits 7:0 only. `busy` rises 2 clocks after the fourth write's strobe release and stays high for PROG_CYC clocks. The word then reads old AND new.
- R4: Sector erase is 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then opcode 30h at any address in the sector. On completion every word of that 2^SEC_AW-word sector reads FFFFh and nothing else changes.
- R5: The same six-write stream ending in opcode 50h erases the whole 2^BLK_AW-word block holding the last address.
- R6: A write whose address or data does not match the expected unlock step returns the interpreter to idle. No operation starts.
- R7: While an operation runs, every write is ignored, except suspend (B0h) during a running erase.
- R8: A B0h write during a running erase holds the erase within SUSP_CYC clocks. `erase_held` is then 1, `busy` is 0 and the array is unchanged.
- R9: While an erase is held, a word program outside the held sector or block is carried out. One inside it is discarded.
- R10: A single 30h write while an erase is held restarts it with its remaining count. `busy` is high again, `erase_held` is 0, and the region is erased when the count runs out.
- R11: With `wp_n` low, an erase whose target lies in the protected block is discarded and `busy` stays 0. The protected block is the highest-indexed block when PROTECT_TOP is 1 and block 0 otherwise.
- R12: The array changes only on the clock that completes an operation. A read taken while an operation is pending shows the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Write address bus |
| wdata | input | 16 | Write data bus |
| wp_n | input | 1 | Write protect, active low |
| rd_addr | input | MEM_AW | Array read address |
| rd_data | output | 16 | Array word at `rd_addr` |
| busy | output | 1 | Internal program, erase or suspend in progress |
| erase_held | output | 1 | An erase is suspended |

## Verification
The bench drives the address bus with a decoy value while only one strobe is low. It also changes the data bus right after the strobes rise. A design that latches on the wrong strobe edge would then program the decoy address or the wrong data.

Full command streams are issued inside a running erase. A design that does not gate its decoder on `busy` would program words that must stay intact.

The suspend test programs both inside and outside the held sector. A design that checks the wrong region, or drops the remaining erase count on resume, leaves a word programmed or an area unerased.

Protected-block erases with `wp_n` low must leave the block unchanged and never raise `busy`. The exact program length is checked on both sides of its end, which catches counters off by one clock.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam logic [15:0] UNLOCK_A1 = 16'h5555;
   localparam logic [15:0] UNLOCK_A2 = 16'h2AAA;
   localparam logic [7:0]  KEY_1     = 8'hAA;
   localparam logic [7:0]  KEY_2     = 8'h55;
   localparam logic [7:0]  OPC_PROG  = 8'hA0;
   localparam logic [7:0]  OPC_ERASE = 8'h80;
   localparam logic [7:0]  OPC_SECT  = 8'h30;
   localparam logic [7:0]  OPC_BLK   = 8'h50;
   localparam logic [7:0]  OPC_HOLD  = 8'hB0;
   localparam logic [7:0]  OPC_RESUME = 8'h30;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_K1, SQ_K2, SQ_PDATA, SQ_E3, SQ_E4, SQ_E5
   } seq_state_t;

   typedef enum logic [2:0] {
      OP_IDLE, OP_PROG, OP_ERASE, OP_HOLDING, OP_HELD, OP_PROG_HELD
   } op_state_t;

endpackage

// File: rtl/flash_strobe_latch.sv
module flash_strobe_latch #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   logic              act, act_q;
   logic [ADDR_W-1:0] a_lat;

   assign act = ~ce_n & ~we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         a_lat    <= '0;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         act_q    <= act;
         wr_valid <= act_q & ~act;
         if (act & ~act_q) a_lat <= addr;
         if (act_q & ~act) begin
            wr_addr <= a_lat;
            wr_data <= wdata;
         end
      end
   end
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic              busy,
   input  logic              erasing,
   input  logic              held,
   output logic              req_prog,
   output logic              req_erase,
   output logic              req_blk,
   output logic              req_hold,
   output logic              req_resume
);
   seq_state_t st, st_nx;
   logic at_a1, at_a2;
   logic [7:0] op;

   assign op    = wr_data[7:0];
   assign at_a1 = (wr_addr == ADDR_W'(UNLOCK_A1));
   assign at_a2 = (wr_addr == ADDR_W'(UNLOCK_A2));

   always_comb begin
      st_nx      = st;
      req_prog   = 1'b0;
      req_erase  = 1'b0;
      req_blk    = 1'b0;
      req_hold   = 1'b0;
      req_resume = 1'b0;
      if (wr_valid) begin
         if (busy) begin
            st_nx    = SQ_IDLE;
            req_hold = erasing && (op == OPC_HOLD);
         end else begin
            st_nx = SQ_IDLE;
            unique case (st)
               SQ_IDLE: begin
                  if (at_a1 && op == KEY_1) st_nx = SQ_K1;
                  else req_resume = held && (op == OPC_RESUME);
               end
               SQ_K1:   if (at_a2 && op == KEY_2) st_nx = SQ_K2;
               SQ_K2: begin
                  if (at_a1 && op == OPC_PROG)  st_nx = SQ_PDATA;
                  if (at_a1 && op == OPC_ERASE) st_nx = SQ_E3;
               end
               SQ_PDATA: req_prog = 1'b1;
               SQ_E3:   if (at_a1 && op == KEY_1) st_nx = SQ_E4;
               SQ_E4:   if (at_a2 && op == KEY_2) st_nx = SQ_E5;
               SQ_E5: begin
                  req_erase = (op == OPC_SECT) || (op == OPC_BLK);
                  req_blk   = (op == OPC_BLK);
               end
               default: st_nx = SQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SQ_IDLE;
      else        st <= st_nx;
   end
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
   import flash_cmd_pkg::*;
#(
   parameter int MEM_AW      = 6,
   parameter int SEC_AW      = 2,
   parameter int BLK_AW      = 4,
   parameter int PROG_CYC    = 12,
   parameter int ERASE_CYC   = 40,
   parameter int SUSP_CYC    = 5,
   parameter bit PROTECT_TOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n,
   input  logic              req_prog,
   input  logic              req_erase,
   input  logic              req_blk,
   input  logic              req_hold,
   input  logic              req_resume,
   input  logic [MEM_AW-1:0] req_idx,
   input  logic [15:0]       req_data,
   input  logic [MEM_AW-1:0] rd_addr,
   output logic [15:0]       rd_data,
   output logic              busy,
   output logic              erasing,
   output logic              held
);
   localparam int DEPTH  = 1 << MEM_AW;
   localparam int BIDX_W = MEM_AW - BLK_AW;
   localparam int MAXC   = (PROG_CYC > ERASE_CYC) ?
                           ((PROG_CYC > SUSP_CYC) ? PROG_CYC : SUSP_CYC) :
                           ((ERASE_CYC > SUSP_CYC) ? ERASE_CYC : SUSP_CYC);
   localparam int CNT_W  = $clog2(MAXC + 1);

   op_state_t         st;
   logic [CNT_W-1:0]  pcnt, ecnt, scnt;
   logic [MEM_AW-1:0] p_idx, e_idx;
   logic [15:0]       p_data;
   logic              e_blk;
   logic [BIDX_W-1:0] prot_blk;
   logic              prot_hit, prog_done, erase_done, prog_ok_held;
   logic [15:0]       mem [DEPTH];

   generate
      if (PROTECT_TOP) begin : g_prot_top
         assign prot_blk = '1;
      end else begin : g_prot_bot
         assign prot_blk = '0;
      end
   endgenerate

   function automatic logic in_region(input logic [MEM_AW-1:0] idx,
                                      input logic [MEM_AW-1:0] base,
                                      input logic              blk);
      if (blk) return idx[MEM_AW-1:BLK_AW] == base[MEM_AW-1:BLK_AW];
      else     return idx[MEM_AW-1:SEC_AW] == base[MEM_AW-1:SEC_AW];
   endfunction

   assign prot_hit     = !wp_n && (req_idx[MEM_AW-1:BLK_AW] == prot_blk);
   assign prog_ok_held = !in_region(req_idx, e_idx, e_blk);
   assign prog_done    = (st == OP_PROG || st == OP_PROG_HELD) && pcnt == '0;
   assign erase_done   = (st == OP_ERASE) && ecnt == '0 && !req_hold;
   assign busy    = (st != OP_IDLE) && (st != OP_HELD);
   assign erasing = (st == OP_ERASE);
   assign held    = (st == OP_HELD) || (st == OP_PROG_HELD);
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= OP_IDLE;
         pcnt   <= '0;
         ecnt   <= '0;
         scnt   <= '0;
         p_idx  <= '0;
         p_data <= '0;
         e_idx  <= '0;
         e_blk  <= 1'b0;
      end else begin
         unique case (st)
            OP_IDLE: begin
               if (req_prog) begin
                  st     <= OP_PROG;
                  pcnt   <= CNT_W'(PROG_CYC - 1);
                  p_idx  <= req_idx;
                  p_data <= req_data;
               end else if (req_erase && !prot_hit) begin
                  st    <= OP_ERASE;
                  ecnt  <= CNT_W'(ERASE_CYC - 1);
                  e_idx <= req_idx;
                  e_blk <= req_blk;
               end
            end
            OP_PROG: begin
               if (pcnt == '0) st <= OP_IDLE;
               else            pcnt <= pcnt - 1'b1;
            end
            OP_ERASE: begin
               if (req_hold) begin
                  st   <= OP_HOLDING;
                  scnt <= CNT_W'(SUSP_CYC - 1);
               end else if (ecnt == '0) st <= OP_IDLE;
               else ecnt <= ecnt - 1'b1;
            end
            OP_HOLDING: begin
               if (scnt == '0) st <= OP_HELD;
               else            scnt <= scnt - 1'b1;
            end
            OP_HELD: begin
               if (req_resume) st <= OP_ERASE;
               else if (req_prog && prog_ok_held) begin
                  st     <= OP_PROG_HELD;
                  pcnt   <= CNT_W'(PROG_CYC - 1);
                  p_idx  <= req_idx;
                  p_data <= req_data;
               end
            end
            OP_PROG_HELD: begin
               if (pcnt == '0) st <= OP_HELD;
               else            pcnt <= pcnt - 1'b1;
            end
            default: st <= OP_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (prog_done) begin
         mem[p_idx] <= mem[p_idx] & p_data;
      end else if (erase_done) begin
         for (int i = 0; i < DEPTH; i++)
            if (in_region(MEM_AW'(i), e_idx, e_blk)) mem[i] <= '1;
      end
   end
endmodule

// File: rtl/flash_cmd_core.sv
module flash_cmd_core #(
   parameter int ADDR_W      = 16,
   parameter int MEM_AW      = 6,
   parameter int SEC_AW      = 2,
   parameter int BLK_AW      = 4,
   parameter int PROG_CYC    = 12,
   parameter int ERASE_CYC   = 40,
   parameter int SUSP_CYC    = 5,
   parameter bit PROTECT_TOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   input  logic              wp_n,
   input  logic [MEM_AW-1:0] rd_addr,
   output logic [15:0]       rd_data,
   output logic              busy,
   output logic              erase_held
);
   generate
      if (ADDR_W < 15 || ADDR_W < MEM_AW)
         $error("ADDR_W must cover the unlock addresses and the array");
      if (!(SEC_AW > 0 && SEC_AW < BLK_AW && BLK_AW < MEM_AW))
         $error("need 0 < SEC_AW < BLK_AW < MEM_AW");
      if (PROG_CYC < 1 || ERASE_CYC < 1 || SUSP_CYC < 1)
         $error("cycle counts must be at least 1");
   endgenerate

   logic              wr_valid;
   logic [ADDR_W-1:0] wr_addr;
   logic [15:0]       wr_data;
   logic              req_prog, req_erase, req_blk, req_hold, req_resume;
   logic              erasing;

   flash_strobe_latch #(.ADDR_W(ADDR_W), .DATA_W(16)) i_latch (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
      .addr(addr), .wdata(wdata),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   flash_cmd_decode #(.ADDR_W(ADDR_W)) i_decode (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .erasing(erasing), .held(erase_held),
      .req_prog(req_prog), .req_erase(req_erase), .req_blk(req_blk),
      .req_hold(req_hold), .req_resume(req_resume)
   );

   flash_op_engine #(
      .MEM_AW(MEM_AW), .SEC_AW(SEC_AW), .BLK_AW(BLK_AW),
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SUSP_CYC(SUSP_CYC),
      .PROTECT_TOP(PROTECT_TOP)
   ) i_engine (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
      .req_prog(req_prog), .req_erase(req_erase), .req_blk(req_blk),
      .req_hold(req_hold), .req_resume(req_resume),
      .req_idx(wr_addr[MEM_AW-1:0]), .req_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .erasing(erasing), .held(erase_held)
   );
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
   parameter int MEM_AW = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              erase_held,
   input logic              wr_valid,
   input logic [MEM_AW-1:0] rd_addr,
   input logic [15:0]       rd_data
);
   AST_WR_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid); // R2

   AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !$past(erase_held)) |-> $past(wr_valid)); // R3

   AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(busy) && $stable(rd_addr)) |-> $stable(rd_data)); // R12

   AST_HOLD_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(erase_held) |-> $past(busy)); // R8

   AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(erase_held) |-> busy); // R10
endmodule

bind flash_cmd_core flash_cmd_checker #(.MEM_AW(MEM_AW)) i_checker (
   .clk(clk), .rst_n(rst_n), .busy(busy), .erase_held(erase_held),
   .wr_valid(wr_valid), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_flash_cmd_core.sv
module test_flash_cmd_core;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W    = 16;
   localparam int MEM_AW    = 6;
   localparam int SEC_AW    = 2;
   localparam int BLK_AW    = 4;
   localparam int PROG_CYC  = 12;
   localparam int ERASE_CYC = 40;
   localparam int SUSP_CYC  = 5;
   localparam int DEPTH     = 1 << MEM_AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, we_n = 1'b1, wp_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [MEM_AW-1:0] rd_addr = '0;
   logic [15:0] rd_data;
   logic busy, erase_held;

   int checks = 0, fails = 0;
   logic [15:0] model [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_core #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .SEC_AW(SEC_AW),
      .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
      .SUSP_CYC(SUSP_CYC), .PROTECT_TOP(1'b1)) i_flash_cmd_core (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
      .wdata(wdata), .wp_n(wp_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .erase_held(erase_held));

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] hi(logic [7:0] b);
      return {8'($urandom), b};
   endfunction

   task automatic bus_write(logic [15:0] a, logic [15:0] d);
      bit ce_first = 1'($urandom);
      bit ce_rise  = 1'($urandom);
      @(negedge clk); addr = 16'($urandom); wdata = 16'($urandom);
      if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
      @(negedge clk); addr = a;
      if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
      @(negedge clk); addr = ~a; wdata = d;
      @(negedge clk);
      if (ce_rise) ce_n = 1'b1; else we_n = 1'b1;
      @(negedge clk); wdata = ~d; ce_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cmd_prog(logic [15:0] a, logic [15:0] d);
      bus_write(16'h5555, hi(8'hAA));
      bus_write(16'h2AAA, hi(8'h55));
      bus_write(16'h5555, hi(8'hA0));
      bus_write(a, d);
   endtask

   task automatic cmd_erase(logic [15:0] a, bit blk);
      bus_write(16'h5555, hi(8'hAA));
      bus_write(16'h2AAA, hi(8'h55));
      bus_write(16'h5555, hi(8'h80));
      bus_write(16'h5555, hi(8'hAA));
      bus_write(16'h2AAA, hi(8'h55));
      bus_write(a, hi(blk ? 8'h50 : 8'h30));
   endtask

   task automatic wait_idle(string req);
      int n = 0;
      while (busy === 1'b1 && n < 1000) begin @(negedge clk); n++; end
      check(req, 16'(busy), 16'h0);
   endtask

   function automatic void m_prog(int idx, logic [15:0] d);
      model[idx] = model[idx] & d;
   endfunction

   function automatic void m_erase(int idx, bit blk);
      int sh = blk ? BLK_AW : SEC_AW;
      for (int i = 0; i < DEPTH; i++)
         if ((i >> sh) == (idx >> sh)) model[i] = 16'hFFFF;
   endfunction

   task automatic compare_all(string req);
      for (int i = 0; i < DEPTH; i++) begin
         rd_addr = MEM_AW'(i);
         #1;
         check(req, rd_data, model[i]);
      end
   endtask

   task automatic read_check(string req, int idx, logic [15:0] exp);
      rd_addr = MEM_AW'(idx);
      #1;
      check(req, rd_data, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", 16'(busy), 16'h0);
      check("R1 held", 16'(erase_held), 16'h0);
      compare_all("R1");

      // R3 exact program length and AND behaviour; R2 decoy address/data
      cmd_prog(16'hA305, 16'h0FFF);
      check("R3 busy start", 16'(busy), 16'h1);
      read_check("R12 old during program", 5, 16'hFFFF);
      repeat (PROG_CYC - 1) @(negedge clk);
      check("R3 busy last cycle", 16'(busy), 16'h1);
      @(negedge clk);
      check("R3 busy end", 16'(busy), 16'h0);
      m_prog(5, 16'h0FFF);
      cmd_prog(16'h0005, 16'hF0F0);
      wait_idle("R3");
      m_prog(5, 16'hF0F0);
      read_check("R3 and", 5, 16'h00F0);
      compare_all("R2");

      // R6 bad unlock sequences
      bus_write(16'h5555, hi(8'hAA));
      bus_write(16'h2AAB, hi(8'h55));
      bus_write(16'h5555, hi(8'hA0));
      bus_write(16'h0007, 16'h0000);
      check("R6 busy", 16'(busy), 16'h0);
      bus_write(16'h5555, hi(8'hAA));
      bus_write(16'h2AAA, hi(8'h55));
      bus_write(16'h5555, hi(8'h81));
      bus_write(16'h0007, 16'h0000);
      check("R6 busy 2", 16'(busy), 16'h0);
      read_check("R6", 7, 16'hFFFF);

      // R7 commands during a running erase are ignored
      cmd_prog(16'h0029, 16'h1111);
      wait_idle("R7 setup"); m_prog(41, 16'h1111);
      cmd_erase(16'h0028, 1'b0);
      check("R4 busy", 16'(busy), 16'h1);
      read_check("R12 old during erase", 41, 16'h1111);
      cmd_prog(16'h0032, 16'h0000);
      wait_idle("R7");
      m_erase(40, 1'b0);
      read_check("R7", 50, 16'hFFFF);
      compare_all("R4");

      // R8..R10 suspend, program around the held region, resume
      cmd_prog(16'h0008, 16'h1234);
      wait_idle("R8 setup"); m_prog(8, 16'h1234);
      cmd_erase(16'h0009, 1'b0);
      bus_write(16'h7777, hi(8'hB0));
      repeat (SUSP_CYC + 2) @(negedge clk);
      check("R8 held", 16'(erase_held), 16'h1);
      check("R8 busy", 16'(busy), 16'h0);
      read_check("R8 unchanged", 8, 16'h1234);
      cmd_prog(16'h0014, 16'h00FF);
      check("R9 outside busy", 16'(busy), 16'h1);
      wait_idle("R9 outside"); m_prog(20, 16'h00FF);
      check("R9 still held", 16'(erase_held), 16'h1);
      read_check("R9 outside", 20, model[20]);
      cmd_prog(16'h000A, 16'h0000);
      check("R9 inside busy", 16'(busy), 16'h0);
      read_check("R9 inside", 10, 16'hFFFF);
      bus_write(16'h0123, hi(8'h30));
      check("R10 busy", 16'(busy), 16'h1);
      check("R10 held", 16'(erase_held), 16'h0);
      wait_idle("R10");
      m_erase(9, 1'b0);
      compare_all("R10");

      // R11 write protect; R5 block erase
      cmd_prog(16'h0036, 16'h0000);
      wait_idle("R11 setup"); m_prog(54, 16'h0000);
      wp_n = 1'b0;
      cmd_erase(16'h0035, 1'b1);
      check("R11 busy", 16'(busy), 16'h0);
      cmd_erase(16'h0031, 1'b0);
      check("R11 sector busy", 16'(busy), 16'h0);
      read_check("R11", 54, 16'h0000);
      cmd_erase(16'h0003, 1'b1);
      wait_idle("R5 unprotected"); m_erase(3, 1'b1);
      compare_all("R5");
      wp_n = 1'b1;
      cmd_erase(16'h0035, 1'b1);
      wait_idle("R5"); m_erase(53, 1'b1);
      read_check("R5 top", 54, 16'hFFFF);

      // random mix against the model
      for (int k = 0; k < 30; k++) begin
         int op = int'($urandom % 3);
         int idx = int'($urandom % DEPTH);
         logic [15:0] a = {10'($urandom), 6'(idx)};
         wp_n = ($urandom % 4) != 0;
         if (op == 0) begin
            logic [15:0] d = 16'($urandom);
            cmd_prog(a, d);
            wait_idle("R3 rnd");
            m_prog(idx, d);
         end else begin
            bit blk = (op == 2);
            bit prot = !wp_n && ((idx >> BLK_AW) == (DEPTH >> BLK_AW) - 1);
            cmd_erase(a, blk);
            wait_idle(blk ? "R5 rnd" : "R4 rnd");
            if (!prot) m_erase(idx, blk);
         end
         compare_all(op == 0 ? "R3 rnd" : "R11 rnd");
      end

      summary();
      $finish;
   end
endmodule